// File: doc/BRIEF.md
# Interleaved Block Read Controller

The controller answers four-word cache block reads by spreading the words of a block across several memory banks that all have the same fixed access time. A requester presents a block address and a mapping select while `ready_o` is high. The controller then sends each word's access to its bank and collects the results. It returns the block as a stream of words on `rdata_o`, marked by `rvalid_o`, and flags the final word with `rlast_o`.

Two mappings are offered. Word-interleaved mode spreads the four words of a block over four banks by their low address bits. All four accesses therefore overlap, and the words come back on four consecutive cycles: one cycle to send the address, six cycles of bank access, then one cycle per word, for 11 cycles in all. Residue mode uses three banks of eight words each. The bank comes from the word address modulo 3 and the slot inside the bank from the word address modulo 8. Because 3 and 8 share no factor, word addresses 0 to 23 each land on a distinct bank/slot pair. In residue mode two words of a block always meet in the same bank. The later of the two waits until that bank has finished its previous access, but words are still delivered in address order.

Each bank is modelled as a fixed-latency unit whose returned word is a known function of its bank number and slot. This makes the mapping visible at the output.

Top module: `ilv_block_reader`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready_o` is 1 and `rvalid_o` and `rlast_o` are 0.
- R2: With `mode_i`=0 at acceptance, word k of block b has word address a=4b+k, bank a mod 4 and slot a/4. The word delivered for bank n and slot r is n*65536+r.
- R3: With `mode_i`=0, a request accepted at clock edge E delivers its four words after edges E+8, E+9, E+10 and E+11, back to back.
- R4: With `mode_i`=1, word address a=4b+k maps to bank a mod 3 and slot a mod 8, and the word delivered is bank*65536+slot. For example, address 8 gives 0x00020000 and address 9 gives 0x00000001.
- R5: With `mode_i`=1, words leave in address order. The fourth word shares a bank with the first, so it is sent only when that bank's six-cycle access ends. Its output follows edge E+14, while the first three words follow edges E+8, E+9 and E+10.
- R6: `rlast_o` is 1 exactly on the fourth word of each block.
- R7: `ready_o` is 0 from the accepting edge until the last word is delivered. Requests presented meanwhile are ignored and produce no extra words.
- R8: `mode_i` and `blk_addr_i` are sampled only at acceptance. Changing them during a block does not alter that block's words or timing.
- R9: `ready_o` is 1 in the cycle the last word is on the output, so a new request can be accepted at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Block read request, taken when `ready_o` is high |
| mode_i | input | 1 | Mapping select: 0 word-interleaved, 1 residue |
| blk_addr_i | input | BLK_AW | Block address (word address divided by four) |
| ready_o | output | 1 | Controller idle and able to accept a request |
| rdata_o | output | WORD_W | Returned word |
| rvalid_o | output | 1 | `rdata_o` carries a word of the current block |
| rlast_o | output | 1 | Marks the final word of a block |

## Verification
The two functions that can land on one edge are a bank finishing an access and the same bank being sent a new one. In residue mode this always happens for the first and fourth words of a block, at edge E+7. Every residue-mode block therefore provokes it. It is judged by the fourth word's value, which must be the fourth word's bank and slot and not a copy of the first word, and by its arrival after exactly edge E+14. A second coincidence, the last word leaving while a new request waits, is provoked by issuing blocks back to back and judged by the next block's words arriving on the cycle counts computed from the earliest possible acceptance.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic {
    MAP_ILV = 1'b0,
    MAP_MOD = 1'b1
  } map_mode_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilv_bank_unit.sv
// One memory bank with a fixed access time. Busy while its counter runs;
// may take a new access on the same edge its current one completes.
module ilv_bank_unit #(
  parameter int UNIT_ID    = 0,
  parameter int WORD_W     = 32,
  parameter int ROW_W      = 8,
  parameter int TAG_W      = 2,
  parameter int ACCESS_LAT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              free_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int CNT_W  = $clog2(ACCESS_LAT + 1);
  localparam int HALF_W = WORD_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tag_q <= '0;
      row_q <= '0;
    end else if (issue_i) begin
      cnt_q <= CNT_W'(ACCESS_LAT);
      tag_q <= tag_i;
      row_q <= row_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign free_o = (cnt_q <= CNT_W'(1));
  assign done_o = (cnt_q == CNT_W'(1));
  assign tag_o  = tag_q;
  assign data_o = (WORD_W'(UNIT_ID) << HALF_W) | WORD_W'(row_q);

  AST_BANK_IDLE_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (cnt_q <= CNT_W'(1))); // R5

endmodule

// File: rtl/ilv_issue_sel.sv
// In-order issue: each pending word goes to its bank if that bank is free;
// the first word that cannot go holds back all later words.
module ilv_issue_sel #(
  parameter int NWORDS = 4,
  parameter int NUNITS = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int TAG_W  = 2
) (
  input  logic [NWORDS-1:0]             pend_i,
  input  logic [NWORDS-1:0][BANK_W-1:0] bank_i,
  input  logic [NWORDS-1:0][ROW_W-1:0]  row_i,
  input  logic [NUNITS-1:0]             free_i,
  output logic [NWORDS-1:0]             go_o,
  output logic [NUNITS-1:0]             issue_o,
  output logic [NUNITS-1:0][TAG_W-1:0]  tag_o,
  output logic [NUNITS-1:0][ROW_W-1:0]  row_o
);
  logic              blocked;
  logic [NUNITS-1:0] claimed;

  always_comb begin
    blocked = 1'b0;
    claimed = '0;
    go_o    = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (pend_i[k] && !blocked) begin
        if (free_i[bank_i[k]] && !claimed[bank_i[k]]) begin
          go_o[k]             = 1'b1;
          claimed[bank_i[k]] = 1'b1;
        end else begin
          blocked = 1'b1;
        end
      end
    end
  end

  always_comb begin
    issue_o = '0;
    tag_o   = '0;
    row_o   = '0;
    for (int u = 0; u < NUNITS; u++) begin
      for (int k = 0; k < NWORDS; k++) begin
        if (go_o[k] && (bank_i[k] == BANK_W'(u))) begin
          issue_o[u] = 1'b1;
          tag_o[u]   = TAG_W'(k);
          row_o[u]   = row_i[k];
        end
      end
    end
  end

endmodule

// File: rtl/ilv_reorder.sv
// Collects bank results into per-word slots and emits them in word order
// through a registered output stage.
module ilv_reorder #(
  parameter int NWORDS = 4,
  parameter int NUNITS = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          run_i,
  input  logic [NUNITS-1:0]             done_i,
  input  logic [NUNITS-1:0][TAG_W-1:0]  tag_i,
  input  logic [NUNITS-1:0][WORD_W-1:0] data_i,
  output logic                          blk_end_o,
  output logic [WORD_W-1:0]             rdata_o,
  output logic                          rvalid_o,
  output logic                          rlast_o
);
  localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(NWORDS - 1);

  logic [WORD_W-1:0] slot_q [NWORDS];
  logic [NWORDS-1:0] filled_q;
  logic [TAG_W-1:0]  nxt_q;
  logic              emit;

  assign emit      = run_i && filled_q[nxt_q];
  assign blk_end_o = emit && (nxt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUNITS; u++) begin
      if (done_i[u]) slot_q[tag_i[u]] <= data_i[u];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled_q <= '0;
      nxt_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      rlast_o  <= 1'b0;
    end else begin
      if (start_i) begin
        filled_q <= '0;
        nxt_q    <= '0;
      end else begin
        for (int u = 0; u < NUNITS; u++) begin
          if (done_i[u]) filled_q[tag_i[u]] <= 1'b1;
        end
        if (emit) nxt_q <= (nxt_q == LAST_IDX) ? '0 : nxt_q + 1'b1;
      end
      if (emit) begin
        rdata_o  <= slot_q[nxt_q];
        rvalid_o <= 1'b1;
        rlast_o  <= (nxt_q == LAST_IDX);
      end else begin
        rvalid_o <= 1'b0;
        rlast_o  <= 1'b0;
      end
    end
  end

  for (genvar u = 0; u < NUNITS; u++) begin : g_chk
    AST_SLOT_FRESH: assert property (@(posedge clk) disable iff (rst)
      done_i[u] |-> !filled_q[tag_i[u]]); // R5
  end

  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (rvalid_o && rlast_o) |=> !rvalid_o); // R7

endmodule

// File: rtl/ilv_block_reader.sv
module ilv_block_reader #(
  parameter int WORD_W      = 32,
  parameter int BLK_AW      = 8,
  parameter int BLOCK_WORDS = 4,
  parameter int ACCESS_LAT  = 6,
  parameter int MOD_BANKS   = 3,
  parameter int MOD_DEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              mode_i,
  input  logic [BLK_AW-1:0] blk_addr_i,
  output logic              ready_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              rlast_o
);
  import ilv_pkg::*;

  localparam int NUM_UNITS = max2(BLOCK_WORDS, MOD_BANKS);
  localparam int BANK_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int WIDX_W    = $clog2(BLOCK_WORDS);
  localparam int AW        = BLK_AW + WIDX_W;
  localparam int ROW_W     = BLK_AW;

  logic                                 active_q;
  map_mode_e                            mode_q;
  logic [BLOCK_WORDS-1:0]               pend_q;
  logic [BLOCK_WORDS-1:0]               go;
  logic [BLOCK_WORDS-1:0][BANK_W-1:0]   bank_d, bank_q;
  logic [BLOCK_WORDS-1:0][ROW_W-1:0]    row_d, row_q;
  logic [NUM_UNITS-1:0]                 u_free, u_issue, u_done;
  logic [NUM_UNITS-1:0][WIDX_W-1:0]     u_tag_in, u_tag_out;
  logic [NUM_UNITS-1:0][ROW_W-1:0]      u_row_in;
  logic [NUM_UNITS-1:0][WORD_W-1:0]     u_data;
  logic                                 accept;
  logic                                 blk_end;

  assign accept  = req_i && !active_q;
  assign ready_o = !active_q;

  // Address mapping for each word of the requested block
  for (genvar k = 0; k < BLOCK_WORDS; k++) begin : g_map
    logic [AW-1:0] waddr;
    assign waddr     = {blk_addr_i, WIDX_W'(k)};
    assign bank_d[k] = mode_i ? BANK_W'(waddr % AW'(MOD_BANKS))
                              : BANK_W'(waddr % AW'(BLOCK_WORDS));
    assign row_d[k]  = mode_i ? ROW_W'(waddr % AW'(MOD_DEPTH))
                              : ROW_W'(waddr / AW'(BLOCK_WORDS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= MAP_ILV;
      pend_q   <= '0;
      bank_q   <= '0;
      row_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      mode_q   <= map_mode_e'(mode_i);
      pend_q   <= '1;
      bank_q   <= bank_d;
      row_q    <= row_d;
    end else begin
      pend_q <= pend_q & ~go;
      if (blk_end) active_q <= 1'b0;
    end
  end

  ilv_issue_sel #(
    .NWORDS (BLOCK_WORDS),
    .NUNITS (NUM_UNITS),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .TAG_W  (WIDX_W)
  ) u_issue_sel (
    .pend_i  (pend_q),
    .bank_i  (bank_q),
    .row_i   (row_q),
    .free_i  (u_free),
    .go_o    (go),
    .issue_o (u_issue),
    .tag_o   (u_tag_in),
    .row_o   (u_row_in)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_bank
    ilv_bank_unit #(
      .UNIT_ID    (u),
      .WORD_W     (WORD_W),
      .ROW_W      (ROW_W),
      .TAG_W      (WIDX_W),
      .ACCESS_LAT (ACCESS_LAT)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .issue_i (u_issue[u]),
      .tag_i   (u_tag_in[u]),
      .row_i   (u_row_in[u]),
      .free_o  (u_free[u]),
      .done_o  (u_done[u]),
      .tag_o   (u_tag_out[u]),
      .data_o  (u_data[u])
    );
  end

  ilv_reorder #(
    .NWORDS (BLOCK_WORDS),
    .NUNITS (NUM_UNITS),
    .WORD_W (WORD_W),
    .TAG_W  (WIDX_W)
  ) u_reorder (
    .clk       (clk),
    .rst       (rst),
    .start_i   (accept),
    .run_i     (active_q),
    .done_i    (u_done),
    .tag_i     (u_tag_out),
    .data_i    (u_data),
    .blk_end_o (blk_end),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o),
    .rlast_o   (rlast_o)
  );

  AST_ILV_STREAM: assert property (@(posedge clk) disable iff (rst)
    (rvalid_o && !rlast_o && mode_q == MAP_ILV) |=> rvalid_o); // R3

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (rvalid_o && !rlast_o) |-> !ready_o); // R7

  AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (u_issue == '0)); // R7

endmodule

// File: tb/ilv_block_reader_bench.sv
module ilv_block_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [7:0]  blk_addr_i = '0;
  logic        ready_o;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic        rlast_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_block_reader u_ilv_block_reader (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .mode_i     (mode_i),
    .blk_addr_i (blk_addr_i),
    .ready_o    (ready_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .rlast_o    (rlast_o)
  );

  typedef struct {
    logic [31:0] data;
    bit          last;
    int          cyc;
    bit          mode;
    bit          poked;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fails = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  // Bank and slot per requirement R2 (interleaved) or R4 (residue)
  function automatic logic [31:0] exp_word(input bit m, input int blk, input int k);
    int a, bank, slot;
    a = blk * 4 + k;
    if (m) begin bank = a % 3; slot = a % 8; end
    else   begin bank = a % 4; slot = a / 4; end
    return 32'(bank * 65536 + slot);
  endfunction

  // Output edge offsets: R3 (8..11) and R5 (8,9,10,14)
  function automatic int exp_ofs(input bit m, input int k);
    if (m && k == 3) return 14;
    return 8 + k;
  endfunction

  task automatic send_block(input bit m, input int blk, input bit poke);
    int acc;
    while (!ready_o) @(negedge clk);
    req_i = 1'b1; mode_i = m; blk_addr_i = 8'(blk);
    acc = cyc + 1;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.data = exp_word(m, blk, k);
      e.last = (k == 3);
      e.cyc  = acc + exp_ofs(m, k);
      e.mode = m;
      e.poked = poke;
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_i = 1'b0;
    if (poke) begin
      // R7, R8: requests and input changes while busy must be ignored
      for (int i = 0; i < 5; i++) begin
        req_i = 1'b1; mode_i = ~m; blk_addr_i = 8'(blk + 3 + i);
        @(negedge clk);
      end
      req_i = 1'b0; mode_i = m;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rvalid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected word", rdata_o, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rdata_o == e.data, e.poked ? "R8" : (e.mode ? "R4" : "R2"), "data", rdata_o, e.data);
        chk(cyc == e.cyc, e.poked ? "R8" : (e.mode ? "R5" : "R3"), "edge", cyc, e.cyc);
        chk(rlast_o == e.last, "R6", "last", rlast_o, e.last);
        if (e.last) chk(ready_o == 1'b1, "R9", "ready at last", ready_o, 1);
        else        chk(ready_o == 1'b0, "R7", "ready while busy", ready_o, 0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ready_o == 1'b1 && rvalid_o == 1'b0 && rlast_o == 1'b0, "R1", "reset outputs",
        {ready_o, rvalid_o, rlast_o}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(ready_o == 1'b1 && rvalid_o == 1'b0 && rlast_o == 1'b0, "R1", "after reset",
        {ready_o, rvalid_o, rlast_o}, 3'b100);

    // R2, R3: interleaved blocks, back to back (R9)
    send_block(1'b0, 0, 1'b0);
    send_block(1'b0, 1, 1'b0);
    send_block(1'b0, 7, 1'b0);
    send_block(1'b0, 255, 1'b0);
    // R4, R5: residue mode over all 24 word addresses
    for (int b = 0; b < 6; b++) send_block(1'b1, b, 1'b0);
    // R7, R8: disturbance while busy, both modes
    send_block(1'b1, 2, 1'b1);
    send_block(1'b0, 5, 1'b1);
    // Alternating modes back to back
    send_block(1'b0, 3, 1'b0);
    send_block(1'b1, 4, 1'b0);
    send_block(1'b0, 128, 1'b0);
    send_block(1'b1, 1, 1'b0);

    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "words outstanding", exp_q.size(), 0);
    chk(ready_o == 1'b1 && rvalid_o == 1'b0, "R9", "idle at end", {ready_o, rvalid_o}, 2'b10);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule